// File: doc/BRIEF.md
# Dual-Band Multi-Modulus Prescaler

This block divides its input clock by one of four ratios: 32, 33, 47 or 48. A band input picks the ratio pair: the low band gives 32/33 and the high band gives 47/48. A modulus input then picks one ratio of that pair. Once per completed division cycle the block emits a pulse one input clock wide. It is the high-speed front stage of an integer-N feedback divider, and a swallow counter and a program counter sit behind it.

The divider is a chain of five divide-by-2/3 cells. The first cell is enabled on every input clock, and each later cell advances once for each cycle of the cell below it. Each cell divides by 2 unless its swallow input is set while the cells above it are in their last step, and then it divides by 3 for that step. A cell with weight 2^i therefore adds 2^i clocks to the cycle. The four ratios come from one small decoder, which is a multiplexer plus an inverted copy of one swallow pattern. The decoder drives the swallow inputs, so all four ratios share the same flip-flops.

The band and modulus inputs are latched only at a division-cycle boundary. The first latch happens on the first clock after reset.

Top module: `mmp_prescaler`

## Requirements
- R1: With band_i=0 and mod_i=0, pulse_o is asserted once every 33 clocks.
- R2: With band_i=0 and mod_i=1, pulse_o is asserted once every 32 clocks.
- R3: With band_i=1 and mod_i=0, pulse_o is asserted once every 48 clocks.
- R4: With band_i=1 and mod_i=1, pulse_o is asserted once every 47 clocks.
- R5: pulse_o is high for exactly one clock per division cycle.
- R6: After rst_ni is released, the first pulse_o appears after exactly the selected ratio of rising clock edges, counting the first edge after release as 1.
- R7: A change of band_i or mod_i in the middle of a cycle leaves the length of that cycle unchanged. The new ratio applies from the next cycle.
- R8: While rst_ni is low, pulse_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| band_i | input | 1 | Band select: 0 selects 32/33, 1 selects 47/48 |
| mod_i | input | 1 | Modulus select: 0 selects the larger ratio, 1 the smaller |
| pulse_o | output | 1 | One-clock pulse at the end of every division cycle |

## Verification
On every cycle, the assertions compare a free-running period counter against the ratio latched for the current cycle, check that the pulse is one clock wide and that the pulse is held low in reset. They also check that each cell enters its stretch step only when it was asked to, and that the latched ratio moves only at a cycle boundary. Whether the latched ratio is the right one for each band and modulus setting, whether the first pulse after reset arrives on time, and when a mid-cycle change takes effect can only be shown by the bench's scenarios. Those scenarios measure the intervals at the output port.

// File: rtl/mmp_pkg.sv
package mmp_pkg;
  typedef enum logic [1:0] {
    PH_A = 2'd0,  // first step
    PH_B = 2'd1,  // second step, last unless stretched
    PH_X = 2'd2   // stretch step
  } cell_ph_e;
endpackage

// File: rtl/mmp_cell.sv
module mmp_cell
  import mmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic swallow_i,
  input  logic mod_i,
  output logic tick_o,
  output logic mod_o
);
  cell_ph_e ph_q;
  logic     stretch;
  logic     last;

  assign stretch = mod_i & swallow_i;
  assign last    = ((ph_q == PH_B) && !stretch) || (ph_q == PH_X);
  assign tick_o  = tick_i & last;
  assign mod_o   = mod_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_A;
    else if (tick_i) begin
      unique case (ph_q)
        PH_A:    ph_q <= PH_B;
        PH_B:    ph_q <= stretch ? PH_X : PH_A;
        default: ph_q <= PH_A;
      endcase
    end
  end

  // R1 R2 R3 R4: a stretch step is only entered when requested
  a_r1_stretch_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_X && $past(ph_q) != PH_X) |-> $past(stretch && tick_i));
  a_r1_stretch_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_X && tick_i) |=> ph_q == PH_A);
  a_r1_ph_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != 2'd3);
endmodule

// File: rtl/mmp_mode.sv
module mmp_mode #(
  parameter int unsigned STAGES  = 5,
  parameter int unsigned SW_LOW  = 1,
  parameter int unsigned SW_HIGH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              band_i,
  input  logic              mod_i,
  input  logic              wrap_i,
  output logic [STAGES-1:0] pgm_o
);
  localparam logic [STAGES-1:0] PGM_LO  = STAGES'(SW_LOW);
  localparam logic [STAGES-1:0] PGM_HI  = STAGES'(SW_HIGH);
  localparam logic [STAGES-1:0] PGM_HI1 = STAGES'(SW_HIGH - 1);

  logic              run_q;
  logic [STAGES-1:0] pgm_q;
  logic [STAGES-1:0] pgm_live;

  // high band: mux between the pattern and its one-less variant
  always_comb begin
    if (band_i) pgm_live = mod_i ? PGM_HI1 : PGM_HI;
    else        pgm_live = mod_i ? '0 : PGM_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pgm_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (!run_q || wrap_i) pgm_q <= pgm_live;
    end
  end

  assign pgm_o = run_q ? pgm_q : pgm_live;

  // R7: latched ratio only moves at a cycle boundary
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !wrap_i) |=> $stable(pgm_q));
endmodule

// File: rtl/mmp_prescaler.sv
module mmp_prescaler #(
  parameter int unsigned STAGES  = 5,
  parameter int unsigned SW_LOW  = 1,
  parameter int unsigned SW_HIGH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic band_i,
  input  logic mod_i,
  output logic pulse_o
);
  localparam int unsigned CW = STAGES + 1;

  logic [STAGES:0]   tick_c;
  logic [STAGES:0]   mod_c;
  logic [STAGES-1:0] pgm;
  logic              wrap;
  logic              pulse_q;

  assign tick_c[0]      = 1'b1;
  assign mod_c[STAGES]  = 1'b1;
  assign wrap           = tick_c[STAGES];

  mmp_mode #(.STAGES(STAGES), .SW_LOW(SW_LOW), .SW_HIGH(SW_HIGH)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .band_i (band_i),
    .mod_i  (mod_i),
    .wrap_i (wrap),
    .pgm_o  (pgm)
  );

  for (genvar i = 0; i < STAGES; i++) begin : g_cell
    mmp_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_c[i]),
      .swallow_i (pgm[i]),
      .mod_i     (mod_c[i+1]),
      .tick_o    (tick_c[i+1]),
      .mod_o     (mod_c[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= wrap;
  end

  assign pulse_o = pulse_q;

  // period checker: clocks since reset or last wrap
  logic [CW-1:0] per_q;
  logic [CW-1:0] ratio;
  assign ratio = {1'b1, pgm};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   per_q <= '0;
    else if (wrap) per_q <= '0;
    else           per_q <= per_q + CW'(1);
  end

  // R1 R2 R3 R4: wrap lands exactly on the selected ratio
  a_r1_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> per_q == ratio - CW'(1));
  a_r1_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q < ratio);
  a_r1_mod_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> mod_c[0]);
  a_r5_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r8_reset_low: assert (!pulse_o);
  end
endmodule

// File: tb/mmp_prescaler_test.sv
`timescale 1ns/1ps
module mmp_prescaler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic band = 1'b0;
  logic md = 1'b0;
  logic pulse;
  int   errors = 0;
  int   checks = 0;

  always #2 clk = ~clk;

  mmp_prescaler uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .band_i (band),
    .mod_i  (md),
    .pulse_o(pulse)
  );

  // band, mod, expected ratio, requirement
  localparam int    NV = 4;
  localparam int    VBAND [NV] = '{0, 0, 1, 1};
  localparam int    VMOD  [NV] = '{0, 1, 0, 1};
  localparam int    VRAT  [NV] = '{33, 32, 48, 47};
  localparam string VREQ  [NV] = '{"R1", "R2", "R3", "R4"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < 200);
    if (!pulse) n = -1;
  endtask

  task automatic do_reset(input logic b, input logic m);
    @(negedge clk);
    rst_n = 1'b0;
    band  = b;
    md    = m;
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R8", int'(pulse), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    for (int v = 0; v < NV; v++) begin
      do_reset(1'(VBAND[v]), 1'(VMOD[v]));
      wait_pulse(n);
      check(n == VRAT[v], "R6", n, VRAT[v]);
      @(negedge clk);
      check(pulse == 1'b0, "R5", int'(pulse), 0);
      wait_pulse(n);
      check(n == VRAT[v] - 1, VREQ[v], n, VRAT[v] - 1);
      for (int k = 0; k < 2; k++) begin
        wait_pulse(n);
        check(n == VRAT[v], VREQ[v], n, VRAT[v]);
      end
    end

    // R7: switch 33 -> 47 mid cycle
    do_reset(1'b0, 1'b0);
    wait_pulse(n);
    repeat (10) @(negedge clk);
    band = 1'b1;
    md   = 1'b1;
    wait_pulse(n);
    check(n == 23, "R7", n, 23);
    wait_pulse(n);
    check(n == 47, "R7", n, 47);

    // R7: toggling mod many times within a 48 cycle, settle on 48
    band = 1'b1;
    md   = 1'b0;
    wait_pulse(n);
    check(n == 47, "R7", n, 47);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      md = ~md;
      band = k[0];
    end
    band = 1'b1;
    md   = 1'b0;
    wait_pulse(n);
    check(n == 48 - 20, "R7", n, 28);
    wait_pulse(n);
    check(n == 48, "R3", n, 48);

    // R8: reset asserted mid cycle clears the cycle
    repeat (5) @(negedge clk);
    do_reset(1'b0, 1'b1);
    wait_pulse(n);
    check(n == 32, "R6", n, 32);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule